// File: doc/BRIEF.md
# Byte-Command Register Access Engine

This block lets a byte stream drive a register bus. Bytes come in over a request/acknowledge handshake and wait in a small receive FIFO. A control state machine reads them from the FIFO and looks for a command frame. A command frame opens with 0x55 and closes with 0xAA, and carries an opcode plus any address and data bytes. The engine then runs one bus read, one bus write or one pulse on the core reset line. It answers with a reply frame sent over a matching handshake. A reply frame opens with 0xAA and closes with 0x55.

A reply holds a status code. On success it also repeats the address and, for a read, carries the data read back. An unknown opcode, a missing end marker and an error flagged by the bus each produce a short reply with a failure code. The block sits between a serial link, such as a UART receiver and transmitter, and the register interface of the core under test.

Top module: `cmd_bus_engine`

## Requirements
- R1: After `rx_req_i` rises, `rx_ack_o` is high in the next cycle if the FIFO has room. `rx_ack_o` stays high while `rx_req_i` is held and goes low one cycle after `rx_req_i` drops. Each handshake stores exactly one byte.
- R2: The receive FIFO holds 8 bytes. When 8 bytes are waiting, `rx_ack_o` stays low until the engine takes a byte.
- R3: Bytes that arrive while the engine is looking for a frame and are not 0x55 are discarded. Every reply starts with 0xAA and ends with 0x55.
- R4: Opcode 0x10 is a read. The frame is 0x55, 0x10, address high byte, address low byte, 0xAA. The bus read holds `core_sel_o` high with `core_wr_o` low for two cycles. `core_rdata_i` is sampled at the end of the second cycle. The reply is 0xAA, 0x7F, the two address bytes, the four data bytes most significant first, 0x55.
- R5: Opcode 0x11 is a write. The frame carries two address bytes high first, then four data bytes most significant first, then 0xAA. The bus write holds `core_sel_o` and `core_wr_o` high for one cycle. The reply is 0xAA, 0x7E, the two address bytes, 0x55.
- R6: Opcode 0x01 with a correct end marker drives `core_rst_no` low for exactly one cycle. The reply is 0xAA, 0x7D, 0x55.
- R7: Any other opcode gets the reply 0xAA, 0xFE, 0x55 and causes no bus access.
- R8: If the byte where 0xAA is expected has another value, there is no bus access and no core reset. The reply is 0xAA, 0xFD, 0x55.
- R9: If `core_err_i` is high in the last select cycle of an access, the reply is 0xAA, 0xFD, 0x55 instead of the success reply.
- R10: `tx_req_o` and `tx_byte_o` stay unchanged until `tx_ack_i` is high. `tx_req_o` drops in the next cycle. The next byte is presented only after `tx_ack_i` has gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_req_i | input | 1 | Sender has a byte on `rx_byte_i` |
| rx_byte_i | input | 8 | Incoming byte |
| rx_ack_o | output | 1 | Byte taken |
| tx_req_o | output | 1 | Reply byte valid on `tx_byte_o` |
| tx_byte_o | output | 8 | Outgoing reply byte |
| tx_ack_i | input | 1 | Receiver took the reply byte |
| core_rst_no | output | 1 | Core reset pulse, active low |
| core_sel_o | output | 1 | Bus access active |
| core_wr_o | output | 1 | Access is a write |
| core_addr_o | output | ADDR_W | Bus address |
| core_wdata_o | output | DATA_W | Write data |
| core_rdata_i | input | DATA_W | Read data, valid one cycle after select rises |
| core_err_i | input | 1 | Bus error for the current access |

## Verification
The receive acknowledge is due one cycle after the request rises and is gone one cycle after the request falls. The bench checks both by counting negative edges between driving the request and seeing the acknowledge. The reference memory registers read data one edge after select rises, so a read that samples one cycle too early returns stale data, and the byte-by-byte reply comparison reports it. On every clock a monitor measures the width of each select pulse and each reset pulse and compares it with the expected width. The acknowledging receiver adds a varying delay of zero to three cycles before each acknowledge. While it waits it checks that the reply byte stays unchanged, and while it holds the acknowledge high it checks that the request has dropped and that no new byte appears.

// File: rtl/cbe_pkg.sv
package cbe_pkg;
  localparam logic [7:0] CMD_SOF     = 8'h55;
  localparam logic [7:0] CMD_EOF     = 8'hAA;
  localparam logic [7:0] RSP_SOF     = 8'hAA;
  localparam logic [7:0] RSP_EOF     = 8'h55;
  localparam logic [7:0] OP_RST      = 8'h01;
  localparam logic [7:0] OP_RD       = 8'h10;
  localparam logic [7:0] OP_WR       = 8'h11;
  localparam logic [7:0] ST_RD_OK    = 8'h7F;
  localparam logic [7:0] ST_WR_OK    = 8'h7E;
  localparam logic [7:0] ST_RST_OK   = 8'h7D;
  localparam logic [7:0] ST_BAD_OP   = 8'hFE;
  localparam logic [7:0] ST_FAIL     = 8'hFD;

  typedef enum logic [3:0] {
    S_HUNT, S_OPC, S_ADDR, S_DATA, S_TAIL, S_RST, S_ACC, S_RDWAIT, S_REPLY
  } cbe_state_e;
endpackage

// File: rtl/cbe_rx_port.sv
module cbe_rx_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic full_i,
  output logic ack_o,
  output logic push_o
);
  logic ack_q;

  assign push_o = req_i && !ack_q && !full_i;
  assign ack_o  = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_i && (ack_q || !full_i);
  end

  // R1
  single_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);
endmodule

// File: rtl/cbe_rx_fifo.sv
module cbe_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_nx, rd_nx;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  generate
    if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nx = wr_q + 1'b1;
      assign rd_nx = rd_q + 1'b1;
    end else begin : g_wrap
      localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
      assign wr_nx = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      assign rd_nx = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    end
  endgenerate

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_nx;
      if (do_pop)  rd_q <= rd_nx;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R2
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  // R2
  push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
endmodule

// File: rtl/cbe_tx_port.sv
module cbe_tx_port (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       ready_o,
  output logic       tx_req_o,
  output logic [7:0] tx_byte_o,
  input  logic       tx_ack_i
);
  logic       valid_q;
  logic [7:0] byte_q;

  // four-phase: wait for ack to clear before the next byte
  assign ready_o   = !valid_q && !tx_ack_i;
  assign tx_req_o  = valid_q;
  assign tx_byte_o = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else if (load_i && ready_o) begin
      valid_q <= 1'b1;
      byte_q  <= byte_i;
    end else if (valid_q && tx_ack_i) begin
      valid_q <= 1'b0;
    end
  end

  // R10
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && !tx_ack_i |=> tx_req_o && $stable(tx_byte_o));
  // R10
  tx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && tx_ack_i |=> !tx_req_o);
endmodule

// File: rtl/cbe_ctrl.sv
module cbe_ctrl import cbe_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [7:0]        fifo_byte_i,
  output logic              fifo_pop_o,
  input  logic              tx_ready_i,
  output logic              tx_load_o,
  output logic [7:0]        tx_byte_o,
  output logic              core_rst_no,
  output logic              core_sel_o,
  output logic              core_wr_o,
  output logic [ADDR_W-1:0] core_addr_o,
  output logic [DATA_W-1:0] core_wdata_o,
  input  logic [DATA_W-1:0] core_rdata_i,
  input  logic              core_err_i
);
  localparam int AB      = ADDR_W / 8;
  localparam int DB      = DATA_W / 8;
  localparam int RSP_MAX = 3 + AB + DB;
  localparam int IDX_W   = $clog2(RSP_MAX + 1);
  localparam int CNT_W   = $clog2(AB + DB + 1);
  localparam logic [IDX_W-1:0] LEN_SHORT = IDX_W'(3);
  localparam logic [IDX_W-1:0] LEN_WR    = IDX_W'(3 + AB);
  localparam logic [IDX_W-1:0] LEN_RD    = IDX_W'(RSP_MAX);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(AB - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DB - 1);

  cbe_state_e        state_q;
  logic [7:0]        op_q, code_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q, len_q;
  logic              take;

  assign take = !fifo_empty_i && (state_q inside {S_HUNT, S_OPC, S_ADDR, S_DATA, S_TAIL});
  assign fifo_pop_o   = take;
  assign tx_load_o    = (state_q == S_REPLY) && tx_ready_i;
  assign core_rst_no  = (state_q != S_RST);
  assign core_sel_o   = (state_q == S_ACC) || (state_q == S_RDWAIT);
  assign core_wr_o    = (state_q == S_ACC) && (op_q == OP_WR);
  assign core_addr_o  = addr_q;
  assign core_wdata_o = data_q;

  always_comb begin
    int k;
    logic [ADDR_W-1:0] a_sh;
    logic [DATA_W-1:0] d_sh;
    k    = int'(idx_q);
    a_sh = '0;
    d_sh = '0;
    if (idx_q == '0)                    tx_byte_o = RSP_SOF;
    else if (idx_q == len_q - 1'b1)     tx_byte_o = RSP_EOF;
    else if (idx_q == IDX_W'(1))        tx_byte_o = code_q;
    else if (k < 2 + AB) begin
      a_sh      = addr_q >> (8 * (AB - 1 - (k - 2)));
      tx_byte_o = a_sh[7:0];
    end else begin
      d_sh      = data_q >> (8 * (DB - 1 - (k - 2 - AB)));
      tx_byte_o = d_sh[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HUNT;
      op_q    <= '0;
      code_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      len_q   <= LEN_SHORT;
    end else begin
      case (state_q)
        S_HUNT: if (take && fifo_byte_i == CMD_SOF) state_q <= S_OPC;
        S_OPC: if (take) begin
          op_q  <= fifo_byte_i;
          cnt_q <= '0;
          case (fifo_byte_i)
            OP_RST:       state_q <= S_TAIL;
            OP_RD, OP_WR: state_q <= S_ADDR;
            default: begin
              code_q  <= ST_BAD_OP;
              len_q   <= LEN_SHORT;
              idx_q   <= '0;
              state_q <= S_REPLY;
            end
          endcase
        end
        S_ADDR: if (take) begin
          addr_q <= {addr_q[ADDR_W-9:0], fifo_byte_i};
          if (cnt_q == ADDR_LAST) begin
            cnt_q   <= '0;
            state_q <= (op_q == OP_WR) ? S_DATA : S_TAIL;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_DATA: if (take) begin
          data_q <= {data_q[DATA_W-9:0], fifo_byte_i};
          if (cnt_q == DATA_LAST) begin
            cnt_q   <= '0;
            state_q <= S_TAIL;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_TAIL: if (take) begin
          idx_q <= '0;
          if (fifo_byte_i != CMD_EOF) begin
            code_q  <= ST_FAIL;
            len_q   <= LEN_SHORT;
            state_q <= S_REPLY;
          end else if (op_q == OP_RST) state_q <= S_RST;
          else                         state_q <= S_ACC;
        end
        S_RST: begin
          code_q  <= ST_RST_OK;
          len_q   <= LEN_SHORT;
          state_q <= S_REPLY;
        end
        S_ACC: begin
          if (op_q == OP_WR) begin
            code_q  <= core_err_i ? ST_FAIL : ST_WR_OK;
            len_q   <= core_err_i ? LEN_SHORT : LEN_WR;
            state_q <= S_REPLY;
          end else state_q <= S_RDWAIT;
        end
        S_RDWAIT: begin
          data_q  <= core_rdata_i;
          code_q  <= core_err_i ? ST_FAIL : ST_RD_OK;
          len_q   <= core_err_i ? LEN_SHORT : LEN_RD;
          state_q <= S_REPLY;
        end
        S_REPLY: if (tx_ready_i) begin
          if (idx_q == len_q - 1'b1) begin
            idx_q   <= '0;
            state_q <= S_HUNT;
          end else idx_q <= idx_q + 1'b1;
        end
        default: state_q <= S_HUNT;
      endcase
    end
  end

  // R6
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_no |=> core_rst_no);
  // R5
  wr_in_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_o |-> core_sel_o);
  // R5
  wr_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_wr_o |=> !core_sel_o);
  // R4
  rd_two_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_sel_o) && !core_wr_o |=> core_sel_o && !core_wr_o);
  // R3
  reply_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o && idx_q == '0 |-> tx_byte_o == RSP_SOF);
endmodule

// File: rtl/cmd_bus_engine.sv
module cmd_bus_engine #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_req_i,
  input  logic [7:0]        rx_byte_i,
  output logic              rx_ack_o,
  output logic              tx_req_o,
  output logic [7:0]        tx_byte_o,
  input  logic              tx_ack_i,
  output logic              core_rst_no,
  output logic              core_sel_o,
  output logic              core_wr_o,
  output logic [ADDR_W-1:0] core_addr_o,
  output logic [DATA_W-1:0] core_wdata_o,
  input  logic [DATA_W-1:0] core_rdata_i,
  input  logic              core_err_i
);
  logic       push, pop, empty, full, tx_ready, tx_load;
  logic [7:0] head_byte, reply_byte;

  cbe_rx_port i_rx_port (
    .clk_i, .rst_ni,
    .req_i  (rx_req_i),
    .full_i (full),
    .ack_o  (rx_ack_o),
    .push_o (push)
  );

  cbe_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .wdata_i (rx_byte_i),
    .pop_i   (pop),
    .rdata_o (head_byte),
    .empty_o (empty),
    .full_o  (full)
  );

  cbe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk_i, .rst_ni,
    .fifo_empty_i (empty),
    .fifo_byte_i  (head_byte),
    .fifo_pop_o   (pop),
    .tx_ready_i   (tx_ready),
    .tx_load_o    (tx_load),
    .tx_byte_o    (reply_byte),
    .core_rst_no, .core_sel_o, .core_wr_o, .core_addr_o,
    .core_wdata_o, .core_rdata_i, .core_err_i
  );

  cbe_tx_port i_tx_port (
    .clk_i, .rst_ni,
    .load_i    (tx_load),
    .byte_i    (reply_byte),
    .ready_o   (tx_ready),
    .tx_req_o,
    .tx_byte_o,
    .tx_ack_i
  );
endmodule

// File: tb/test_cmd_bus_engine.sv
module test_cmd_bus_engine;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam logic [15:0] LIMIT = 16'h0100;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        rx_req = 1'b0, rx_ack;
  logic [7:0]  rx_byte = '0;
  logic        tx_req, tx_ack;
  logic [7:0]  tx_byte;
  logic        core_rst_n, sel, wr, err;
  logic [15:0] addr;
  logic [31:0] wdata, rdata = '0;

  cmd_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(8)) i_cmd_bus_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_req_i(rx_req), .rx_byte_i(rx_byte), .rx_ack_o(rx_ack),
    .tx_req_o(tx_req), .tx_byte_o(tx_byte), .tx_ack_i(tx_ack),
    .core_rst_no(core_rst_n), .core_sel_o(sel), .core_wr_o(wr),
    .core_addr_o(addr), .core_wdata_o(wdata),
    .core_rdata_i(rdata), .core_err_i(err)
  );

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R3";
  bit tx_en = 1'b1;
  logic [7:0]  exp_tx[$];
  logic        exp_wr[$];
  logic [15:0] exp_addr[$];
  logic [31:0] exp_data[$];
  int exp_rst = 0, seen_rst = 0;
  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus-side model: error outside LIMIT, read data registered
  assign err = sel && (addr >= LIMIT);
  always @(posedge clk) begin
    if (sel && !wr) rdata <= (addr < LIMIT) ? mem[addr[7:0]] : 32'hDEAD0000;
    if (sel && wr && addr < LIMIT) mem[addr[7:0]] <= wdata;
  end

  // reply receiver with varying acknowledge delay
  initial begin : acker
    logic [7:0] b0;
    int dly;
    dly = 0;
    tx_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (tx_req && tx_en) begin
        b0 = tx_byte;
        repeat (dly) @(negedge clk);
        chk(tx_req && tx_byte == b0, "R10", "byte held until ack", {tx_req, tx_byte}, {1'b1, b0});
        if (exp_tx.size() == 0) chk(1'b0, cur_tag, "unexpected reply byte", tx_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          chk(tx_byte == e, cur_tag, "reply byte", tx_byte, e);
        end
        tx_ack = 1'b1;
        @(negedge clk);
        chk(!tx_req, "R10", "req drops after ack", tx_req, 0);
        @(negedge clk);
        chk(!tx_req, "R10", "no byte while ack high", tx_req, 0);
        tx_ack = 1'b0;
        dly = (dly + 1) % 4;
      end
    end
  end

  // bus and reset monitor
  logic sel_prev = 1'b0, rst_prev = 1'b1, last_wr = 1'b0;
  int sel_len = 0, rst_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sel && !sel_prev) begin
        if (exp_wr.size() == 0) chk(1'b0, "R7", "unexpected bus access", addr, 0);
        else begin
          logic e_wr;
          logic [15:0] e_a;
          logic [31:0] e_d;
          e_wr = exp_wr.pop_front();
          e_a  = exp_addr.pop_front();
          e_d  = exp_data.pop_front();
          chk(wr == e_wr, e_wr ? "R5" : "R4", "bus direction", wr, e_wr);
          chk(addr == e_a, e_wr ? "R5" : "R4", "bus address", addr, e_a);
          if (e_wr) chk(wdata == e_d, "R5", "write data", wdata, e_d);
        end
        last_wr = wr;
        sel_len = 0;
      end
      if (sel) sel_len++;
      if (!sel && sel_prev)
        chk(sel_len == (last_wr ? 1 : 2), last_wr ? "R5" : "R4", "select width",
            sel_len, last_wr ? 1 : 2);
      if (!core_rst_n) rst_len++;
      if (core_rst_n && !rst_prev) begin
        chk(rst_len == 1, "R6", "core reset width", rst_len, 1);
        if (seen_rst >= exp_rst) chk(1'b0, "R8", "unexpected core reset", seen_rst, exp_rst);
        seen_rst++;
        rst_len = 0;
      end
    end
    sel_prev = sel;
    rst_prev = core_rst_n;
  end

  task automatic send_byte(input logic [7:0] b, input bit lat_chk);
    int n;
    n = 0;
    @(negedge clk);
    rx_byte = b;
    rx_req  = 1'b1;
    do begin @(negedge clk); n++; end while (!rx_ack && n < 5000);
    if (lat_chk) chk(n == 1, "R1", "ack latency", n, 1);
    rx_req = 1'b0;
    @(negedge clk);
    if (lat_chk) chk(!rx_ack, "R1", "ack release", rx_ack, 0);
    while (rx_ack) @(negedge clk);
  endtask

  task automatic wait_drain();
    int n;
    n = 0;
    while ((exp_tx.size() != 0 || exp_wr.size() != 0) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic push_short(input logic [7:0] code);
    exp_tx.push_back(8'hAA); exp_tx.push_back(code); exp_tx.push_back(8'h55);
  endtask

  task automatic do_read(input logic [15:0] a);
    exp_wr.push_back(1'b0); exp_addr.push_back(a); exp_data.push_back('0);
    if (a >= LIMIT) push_short(8'hFD);
    else begin
      exp_tx.push_back(8'hAA); exp_tx.push_back(8'h7F);
      exp_tx.push_back(a[15:8]); exp_tx.push_back(a[7:0]);
      for (int i = 3; i >= 0; i--) exp_tx.push_back(ref_mem[a[7:0]][8*i +: 8]);
      exp_tx.push_back(8'h55);
    end
    send_byte(8'h55, 1'b0); send_byte(8'h10, 1'b0);
    send_byte(a[15:8], 1'b0); send_byte(a[7:0], 1'b0); send_byte(8'hAA, 1'b0);
    wait_drain();
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    exp_wr.push_back(1'b1); exp_addr.push_back(a); exp_data.push_back(d);
    if (a >= LIMIT) push_short(8'hFD);
    else begin
      ref_mem[a[7:0]] = d;
      exp_tx.push_back(8'hAA); exp_tx.push_back(8'h7E);
      exp_tx.push_back(a[15:8]); exp_tx.push_back(a[7:0]); exp_tx.push_back(8'h55);
    end
    send_byte(8'h55, 1'b0); send_byte(8'h11, 1'b0);
    send_byte(a[15:8], 1'b0); send_byte(a[7:0], 1'b0);
    for (int i = 3; i >= 0; i--) send_byte(d[8*i +: 8], 1'b0);
    send_byte(8'hAA, 1'b0);
    wait_drain();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    bit got;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = {4{i[7:0]}};
      ref_mem[i] = {4{i[7:0]}};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rx_ack && !tx_req, "R1", "idle handshakes after reset", {rx_ack, tx_req}, 0);
    chk(!sel && !wr && core_rst_n, "R6", "idle bus after reset", {sel, wr, core_rst_n}, 1);

    // R6 reset command, first byte also times the receive handshake (R1)
    cur_tag = "R6";
    exp_rst++;
    push_short(8'h7D);
    send_byte(8'h55, 1'b1); send_byte(8'h01, 1'b1); send_byte(8'hAA, 1'b1);
    wait_drain();

    cur_tag = "R4";
    do_read(16'h0023);
    do_read(16'h0055);
    cur_tag = "R5";
    do_write(16'h00AA, 32'h1337BEEF);
    cur_tag = "R4";
    do_read(16'h00AA);
    cur_tag = "R5";
    do_write(16'h0010, 32'h55AA55AA);

    // R3 leading junk is dropped
    cur_tag = "R3";
    send_byte(8'h00, 1'b0); send_byte(8'h13, 1'b0); send_byte(8'hAA, 1'b0);
    do_read(16'h0010);

    // R7 unknown opcode
    cur_tag = "R7";
    push_short(8'hFE);
    send_byte(8'h55, 1'b0); send_byte(8'h42, 1'b0); send_byte(8'hAA, 1'b0);
    wait_drain();

    // R8 wrong end marker on a read and on a reset
    cur_tag = "R8";
    push_short(8'hFD);
    send_byte(8'h55, 1'b0); send_byte(8'h10, 1'b0); send_byte(8'h00, 1'b0);
    send_byte(8'h05, 1'b0); send_byte(8'h00, 1'b0);
    wait_drain();
    push_short(8'hFD);
    send_byte(8'h55, 1'b0); send_byte(8'h01, 1'b0); send_byte(8'h77, 1'b0);
    wait_drain();
    cur_tag = "R4";
    do_read(16'h0005);

    // R9 bus error on read and on write
    cur_tag = "R9";
    do_read(16'h0200);
    do_write(16'h0300, 32'hCAFEF00D);

    // R2 fill the FIFO while the reply is stalled
    cur_tag = "R2";
    tx_en = 1'b0;
    exp_rst++;
    push_short(8'h7D);
    send_byte(8'h55, 1'b0); send_byte(8'h01, 1'b0); send_byte(8'hAA, 1'b0);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 8; i++) send_byte(8'h00, 1'b0);
    @(negedge clk);
    rx_byte = 8'h00;
    rx_req  = 1'b1;
    repeat (10) @(negedge clk);
    chk(!rx_ack, "R2", "ack withheld when full", rx_ack, 0);
    tx_en = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      got = rx_ack;
    end
    chk(got, "R2", "ack after space frees", got, 1);
    rx_req = 1'b0;
    while (rx_ack) @(negedge clk);
    wait_drain();

    cur_tag = "R4";
    do_read(16'h00AA);

    repeat (20) @(negedge clk);
    chk(exp_tx.size() == 0, "R3", "all reply bytes seen", exp_tx.size(), 0);
    chk(exp_wr.size() == 0, "R4", "all bus accesses seen", exp_wr.size(), 0);
    chk(seen_rst == exp_rst, "R6", "core reset count", seen_rst, exp_rst);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule